// File: doc/BRIEF.md
# Precise Exception Capture Unit

This block keeps the exception state of a small 32-bit multi-cycle load/store processor. It watches two internal fault sources. The first is an undefined opcode flagged by the decode step. The second is signed overflow flagged by the ALU in the last execute cycle of a register-register arithmetic instruction. When either fault is seen, the block saves the address of the faulting instruction and records a cause code. It then asks the program-counter mux to load one fixed handler entry address.

The program counter has already moved past the faulting instruction when the fault is seen, because it is incremented during fetch. For that reason the saved address is the presented PC minus four. The faulting instruction must not change machine state, so the block also gates the register-file write strobe. The strobe is held low in the fault cycle and in the write-back cycle that follows it.

Top module: `exc_capture_unit`

## Requirements
- R1: While reset is held and after it is released, the saved exception address and the cause code read zero, the handler-select request is low, and the register-file write strobe follows its request.
- R2: At the clock edge where a fault is flagged, the saved exception address takes the value of `pc_i` minus 4, computed modulo 2^32 (a PC of 0 saves 0xFFFF_FFFC). It is visible from the next cycle.
- R3: An undefined-opcode fault writes cause code 0.
- R4: Overflow counts as a fault only when `arith_exec_last_i` is high in the same cycle. Such a fault writes cause code 1.
- R5: When `alu_ovf_i` is high and `arith_exec_last_i` is low, the input has no effect. The saved address and cause hold, no handler select follows, and the write strobe is not gated.
- R6: When both faults are flagged in one cycle, cause code 0 (undefined opcode) is written.
- R7: `pc_handler_sel_o` is high for exactly the one cycle after each fault cycle. `handler_addr_o` always equals the parameter HANDLER_ADDR (default 0x8000_0180).
- R8: `rf_we_o` is low in a fault cycle and in the cycle right after it. In every other cycle it equals `rf_we_req_i`.
- R9: In a cycle with no fault, the saved address and the cause code keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | Current (already incremented) program counter |
| undef_op_i | input | 1 | Decode reports an undefined opcode |
| alu_ovf_i | input | 1 | ALU signed-overflow flag |
| arith_exec_last_i | input | 1 | Last execute cycle of a register-register arithmetic op |
| rf_we_req_i | input | 1 | Register-file write request from control |
| rf_we_o | output | 1 | Gated register-file write strobe |
| epc_o | output | 32 | Saved faulting-instruction address |
| cause_o | output | 4 | Cause code (0 undefined, 1 overflow) |
| pc_handler_sel_o | output | 1 | Request to load the handler address into the PC |
| handler_addr_o | output | 32 | Fixed handler entry address |

## Verification
The bench sweeps all sixteen combinations of the two fault flags, the execute-end qualifier and the write request, at PC values that include zero and the top of the address space.

It targets the following errors:
- A design that drops the minus-four correction or mishandles wrap-around would save the wrong address at PC 0.
- A design that reverses the priority would report overflow when both flags are set.
- A design that does not qualify overflow would redirect on a stray flag.
- A design that forgets the write-back cycle would let the overflowing result reach the register file one cycle late.
- A design that stretches or drops the select pulse would be caught in the two idle cycles checked after each vector.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_UNDEF = 2'd1,
        FK_OVF   = 2'd2
    } fault_kind_e;

    localparam int unsigned CODE_UNDEF = 0;
    localparam int unsigned CODE_OVF   = 1;

    function automatic int unsigned kind_to_code(fault_kind_e k);
        return (k == FK_OVF) ? CODE_OVF : CODE_UNDEF;
    endfunction

endpackage

// File: rtl/exc_fault_arbiter.sv
module exc_fault_arbiter
    import exc_pkg::*;
(
    input  logic        undef_i,
    input  logic        ovf_i,
    input  logic        exec_last_i,
    output logic        take_o,
    output fault_kind_e kind_o
);

    logic ovf_qual;

    always_comb begin
        ovf_qual = ovf_i & exec_last_i;
        take_o   = undef_i | ovf_qual;
        // undecoded instruction cannot overflow: it wins
        if (undef_i)       kind_o = FK_UNDEF;
        else if (ovf_qual) kind_o = FK_OVF;
        else               kind_o = FK_NONE;
    end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4,
    parameter int unsigned PC_STEP = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               epc_we_i,
    input  logic               cause_we_i,
    input  fault_kind_e        cause_sel_i,
    input  logic [XLEN-1:0]    pc_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    typedef struct packed {
        logic [XLEN-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (epc_we_i)   st_d.epc   = pc_i - STEP;
        if (cause_we_i) st_d.cause = CAUSE_W'(kind_to_code(cause_sel_i));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign epc_o   = st_q.epc;
    assign cause_o = st_q.cause;

    AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        epc_we_i |=> (epc_o == $past(pc_i) - STEP)); // R2
    AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!epc_we_i && !cause_we_i) |=> ($stable(epc_o) && $stable(cause_o))); // R9

endmodule

// File: rtl/exc_wb_ctrl.sv
module exc_wb_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fault_i,
    input  logic we_req_i,
    output logic we_o,
    output logic redirect_o
);

    typedef struct packed {
        logic squash;
        logic redirect;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d.squash   = fault_i;
        ctl_d.redirect = fault_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign we_o       = we_req_i & ~fault_i & ~ctl_q.squash;
    assign redirect_o = ctl_q.redirect;

    AST_WB_BLOCK_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |-> !we_o); // R8
    AST_WB_BLOCK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> !we_o); // R8
    AST_SEL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> redirect_o); // R7
    AST_SEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_i |=> !redirect_o); // R7

endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
    import exc_pkg::*;
#(
    parameter int unsigned     XLEN         = 32,
    parameter int unsigned     CAUSE_W      = 4,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               undef_op_i,
    input  logic               alu_ovf_i,
    input  logic               arith_exec_last_i,
    input  logic               rf_we_req_i,
    output logic               rf_we_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               pc_handler_sel_o,
    output logic [XLEN-1:0]    handler_addr_o
);

    logic        take;
    fault_kind_e kind;

    exc_fault_arbiter u_arb (
        .undef_i     (undef_op_i),
        .ovf_i       (alu_ovf_i),
        .exec_last_i (arith_exec_last_i),
        .take_o      (take),
        .kind_o      (kind)
    );

    exc_state_regs #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W),
        .PC_STEP (4)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .epc_we_i    (take),
        .cause_we_i  (take),
        .cause_sel_i (kind),
        .pc_i        (pc_i),
        .epc_o       (epc_o),
        .cause_o     (cause_o)
    );

    exc_wb_ctrl u_wb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fault_i    (take),
        .we_req_i   (rf_we_req_i),
        .we_o       (rf_we_o),
        .redirect_o (pc_handler_sel_o)
    );

    assign handler_addr_o = HANDLER_ADDR;

    AST_CAUSE_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        undef_op_i |=> (cause_o == CAUSE_W'(CODE_UNDEF))); // R3
    AST_CAUSE_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alu_ovf_i && arith_exec_last_i && !undef_op_i) |=> (cause_o == CAUSE_W'(CODE_OVF))); // R4
    AST_STRAY_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!undef_op_i && !arith_exec_last_i) |=> (!pc_handler_sel_o && $stable(epc_o))); // R5

endmodule

// File: tb/test_exc_capture_unit.sv
module test_exc_capture_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] pc_i = '0;
    logic        undef_op_i = 1'b0;
    logic        alu_ovf_i = 1'b0;
    logic        arith_exec_last_i = 1'b0;
    logic        rf_we_req_i = 1'b0;
    logic        rf_we_o;
    logic [31:0] epc_o;
    logic [3:0]  cause_o;
    logic        pc_handler_sel_o;
    logic [31:0] handler_addr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk_i = ~clk_i;

    exc_capture_unit i_exc_capture_unit (
        .clk_i             (clk_i),
        .rst_ni            (rst_ni),
        .pc_i              (pc_i),
        .undef_op_i        (undef_op_i),
        .alu_ovf_i         (alu_ovf_i),
        .arith_exec_last_i (arith_exec_last_i),
        .rf_we_req_i       (rf_we_req_i),
        .rf_we_o           (rf_we_o),
        .epc_o             (epc_o),
        .cause_o           (cause_o),
        .pc_handler_sel_o  (pc_handler_sel_o),
        .handler_addr_o    (handler_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pc_pick(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0004;
            2: return 32'h0000_1000;
            3: return 32'hFFFF_FFFC;
            4: return 32'h8000_0184;
            default: return 32'h1234_5678;
        endcase
    endfunction

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] exp_epc;
        logic [3:0]  exp_cause;
        exp_epc   = '0;
        exp_cause = '0;

        // reset state, R1
        rf_we_req_i = 1'b1;
        repeat (3) @(negedge clk_i);
        #1;
        chk("R1 epc in reset", epc_o, 32'h0);
        chk("R1 cause in reset", {28'h0, cause_o}, 32'h0);
        chk("R1 sel in reset", {31'h0, pc_handler_sel_o}, 32'h0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        chk("R1 epc after reset", epc_o, 32'h0);
        chk("R1 cause after reset", {28'h0, cause_o}, 32'h0);
        chk("R1 sel after reset", {31'h0, pc_handler_sel_o}, 32'h0);
        chk("R1 write strobe passes", {31'h0, rf_we_o}, 32'h1);
        chk("R7 handler address", handler_addr_o, 32'h8000_0180);

        for (int p = 0; p < 6; p++) begin
            for (int v = 0; v < 16; v++) begin
                logic u, o, e, w, f;
                u = v[0]; o = v[1]; e = v[2]; w = v[3];
                f = u | (o & e);
                @(negedge clk_i);
                pc_i = pc_pick(p);
                undef_op_i = u; alu_ovf_i = o; arith_exec_last_i = e; rf_we_req_i = w;
                #2;
                // R8 gating in the fault cycle itself; R5 stray overflow passes
                chk(f ? "R8 strobe in fault cycle" : "R5 strobe not gated",
                    {31'h0, rf_we_o}, {31'h0, w & ~f});
                if (f) begin
                    exp_epc   = pc_pick(p) - 32'd4;
                    exp_cause = u ? 4'd0 : 4'd1;
                end
                @(negedge clk_i);
                undef_op_i = 1'b0; alu_ovf_i = 1'b0; arith_exec_last_i = 1'b0;
                rf_we_req_i = 1'b1;
                pc_i = 32'hDEAD_BEE0;
                #2;
                chk(f ? "R2 epc captured" : "R9 epc held", epc_o, exp_epc);
                chk(u ? (o & e ? "R6 priority" : "R3 cause undef")
                      : (f ? "R4 cause ovf" : "R9 cause held"),
                    {28'h0, cause_o}, {28'h0, exp_cause});
                chk(f ? "R7 sel pulse" : "R5 no sel", {31'h0, pc_handler_sel_o}, {31'h0, f});
                chk("R8 strobe in write-back cycle", {31'h0, rf_we_o}, {31'h0, ~f});
                @(negedge clk_i);
                #2;
                chk("R7 sel one cycle", {31'h0, pc_handler_sel_o}, 32'h0);
                chk("R8 strobe restored", {31'h0, rf_we_o}, 32'h1);
                chk("R9 epc stable idle", epc_o, exp_epc);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule